// File: doc/BRIEF.md
# Lowest-Priority Core Pool Selector

This block steers one interrupt at a time to a single processor core. An interrupt arrives with a 6-bit urgency value and a one-bit-per-core mask of the cores that may take it. Every core continuously reports a ready flag and the 6-bit priority it is running at. The block picks the core that is doing the least important work, as long as that work is still less urgent than the interrupt. It reports the chosen core number with a one-cycle strobe.

When no core can take the interrupt, the block does not hold up its input. It parks the interrupt in a small requeue queue, pulses a miss output and goes on accepting new requests. Parked interrupts are offered again after a short hold-off, and they take precedence over fresh requests. The input handshake closes only while the queue is full or while a parked interrupt is being retried.

Top module: `core_pool_selector`

## Requirements
- R1: A core is eligible only when its mask bit is 1, its ready flag is 1 and its running priority is strictly less than the interrupt priority (a larger number is more urgent). A core whose running priority equals the interrupt priority is not eligible.
- R2: Among eligible cores, the core with the numerically smallest running priority is chosen.
- R3: When several eligible cores share that smallest priority, the one with the lowest core index is chosen.
- R4: The result appears in the cycle after an interrupt is evaluated: `pickValid` is high for exactly one cycle with `pickCore` holding the chosen core index, and exactly one of `pickValid` and `missPulse` is high in that cycle. Both are low after any cycle with no evaluation.
- R5: When no core is eligible, `missPulse` is high for one cycle instead of `pickValid`, and the interrupt (priority and mask) is stored in the requeue queue of `FIFO_DEPTH` entries (8 by default).
- R6: After any miss, the head of the queue is held off for `RETRY_GAP` cycles (4 by default) and is then retried using its own stored priority and mask. While a retry is due, `reqReady` is low, so a queued interrupt is served before any new request.
- R7: Queued interrupts are retried oldest first. When the queue holds `FIFO_DEPTH` entries, `reqReady` is low. The queue never overflows.
- R8: After reset, `pickValid` and `missPulse` are low, the queue is empty and `reqReady` is high.
- R9: A retried interrupt that again finds no eligible core pulses `missPulse` again and moves to the back of the queue. It is retried every `RETRY_GAP`+1 cycles while nothing else misses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | New interrupt offered |
| reqReady | output | 1 | New interrupt accepted at this edge when reqValid is high |
| reqPrio | input | PRIO_W (6) | Interrupt priority |
| reqPool | input | NUM_CORES (64) | Candidate core mask, bit i for core i |
| coreReady | input | NUM_CORES (64) | Per-core ready flags |
| corePrio | input | NUM_CORES*PRIO_W (384) | Per-core running priority, core i in bits [i*PRIO_W +: PRIO_W] |
| pickValid | output | 1 | One-cycle strobe: a core was selected |
| pickCore | output | log2(NUM_CORES) (6) | Index of the selected core |
| missPulse | output | 1 | One-cycle strobe: interrupt was requeued |

## Verification
On every cycle, the assertions check the following. An evaluation produces exactly one of a pick or a miss one cycle later, and idle cycles produce neither. A picked core was eligible when the interrupt was evaluated. A push never overflows the queue. A miss is never followed at once by a retry. The bench scenarios cover the rest. Minimum-priority selection and lowest-index tie-breaking are swept against an arithmetic model. The bench also shows oldest-first draining, with a waiting new request served only after the queue empties, and the exact retry period of a parked interrupt that keeps missing.

// File: rtl/pool_sel_pkg.sv
package pool_sel_pkg;
  // Strobes from the control path to the datapath for one cycle.
  typedef struct packed {
    logic evalValid;  // an interrupt is evaluated this cycle
    logic useRetry;   // evaluated interrupt comes from the queue head
    logic push;       // write the evaluated interrupt to the queue tail
    logic pop;        // drop the queue head
  } selStrobe_t;
endpackage

// File: rtl/pool_sel_dp.sv
module pool_sel_dp
  import pool_sel_pkg::*;
#(
  parameter int NUM_CORES  = 64,
  parameter int PRIO_W     = 6,
  parameter int FIFO_DEPTH = 8,
  localparam int IDX_W = $clog2(NUM_CORES),
  localparam int PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1,
  localparam int ENT_W = PRIO_W + NUM_CORES
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  selStrobe_t                  strobe,
  input  logic [PRIO_W-1:0]           reqPrio,
  input  logic [NUM_CORES-1:0]        reqPool,
  input  logic [NUM_CORES-1:0]        coreReady,
  input  logic [NUM_CORES*PRIO_W-1:0] corePrio,
  output logic                        anyHit,
  output logic                        pickValid,
  output logic [IDX_W-1:0]            pickCore,
  output logic                        missPulse
);

  logic [ENT_W-1:0]     queueMem [FIFO_DEPTH];
  logic [PTR_W-1:0]     rdPtr, wrPtr;
  logic [PRIO_W-1:0]    curPrio;
  logic [NUM_CORES-1:0] curPool;
  logic [NUM_CORES-1:0] eligVec;
  logic [PRIO_W-1:0]    corePrioArr [NUM_CORES];
  logic [IDX_W-1:0]     bestIdx;
  logic [PRIO_W-1:0]    bestPrio;
  logic                 found;

  // Pick the interrupt under evaluation: queue head or new request.
  always_comb begin
    if (strobe.useRetry) begin
      {curPrio, curPool} = queueMem[rdPtr];
    end else begin
      curPrio = reqPrio;
      curPool = reqPool;
    end
  end

  // Per-core eligibility.
  for (genvar i = 0; i < NUM_CORES; i++) begin : g_elig
    assign corePrioArr[i] = corePrio[i*PRIO_W +: PRIO_W];
    assign eligVec[i] = curPool[i] && coreReady[i] && (corePrioArr[i] < curPrio);
  end

  // Minimum running priority, lowest index on ties (strict compare).
  always_comb begin
    found    = 1'b0;
    bestIdx  = '0;
    bestPrio = '1;
    for (int i = 0; i < NUM_CORES; i++) begin
      if (eligVec[i] && (!found || corePrioArr[i] < bestPrio)) begin
        found    = 1'b1;
        bestIdx  = IDX_W'(i);
        bestPrio = corePrioArr[i];
      end
    end
  end

  assign anyHit = found;

  // Registered result.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pickValid <= 1'b0;
      pickCore  <= '0;
      missPulse <= 1'b0;
    end else begin
      pickValid <= strobe.evalValid && found;
      missPulse <= strobe.push;
      if (strobe.evalValid && found) pickCore <= bestIdx;
    end
  end

  // Requeue storage and pointers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdPtr <= '0;
      wrPtr <= '0;
    end else begin
      if (strobe.pop)
        rdPtr <= (rdPtr == PTR_W'(FIFO_DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      if (strobe.push)
        wrPtr <= (wrPtr == PTR_W'(FIFO_DEPTH - 1)) ? '0 : wrPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.push) queueMem[wrPtr] <= {curPrio, curPool};
  end

  // R4: every evaluation yields exactly one of pick or miss next cycle.
  assert_one_result_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.evalValid |=> (pickValid ^ missPulse));

  // R4: no result strobes after an idle cycle.
  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.evalValid |=> (!pickValid && !missPulse));

  // R1: the reported core was eligible when evaluated.
  assert_pick_eligible_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pickValid |-> ((($past(eligVec)) >> pickCore) & NUM_CORES'(1)) != '0);

endmodule

// File: rtl/pool_sel_ctrl.sv
module pool_sel_ctrl
  import pool_sel_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int RETRY_GAP  = 4,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1),
  localparam int GAP_W = $clog2(RETRY_GAP + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reqValid,
  input  logic       anyHit,
  output logic       reqReady,
  output selStrobe_t strobe
);

  logic [CNT_W-1:0] count;
  logic [GAP_W-1:0] gapCnt;
  logic             retryDue;
  logic             queueFull;

  assign queueFull = (count == CNT_W'(FIFO_DEPTH));
  assign retryDue  = (count != '0) && (gapCnt == '0);
  assign reqReady  = rst_n && !queueFull && !retryDue;

  always_comb begin
    strobe.useRetry  = retryDue;
    strobe.evalValid = retryDue || (reqValid && reqReady);
    strobe.push      = strobe.evalValid && !anyHit;
    strobe.pop       = retryDue;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      gapCnt <= '0;
    end else begin
      case ({strobe.push, strobe.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (strobe.push)
        gapCnt <= GAP_W'(RETRY_GAP);
      else if (gapCnt != '0)
        gapCnt <= gapCnt - 1'b1;
    end
  end

  // R7: a net push never happens with a full queue.
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.push && !strobe.pop) |-> (count < CNT_W'(FIFO_DEPTH)));

  // R6: a miss is never followed directly by a retry.
  assert_holdoff_R6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.push |=> !strobe.useRetry);

endmodule

// File: rtl/core_pool_selector.sv
module core_pool_selector
  import pool_sel_pkg::*;
#(
  parameter int NUM_CORES  = 64,
  parameter int PRIO_W     = 6,
  parameter int FIFO_DEPTH = 8,
  parameter int RETRY_GAP  = 4,
  localparam int IDX_W = $clog2(NUM_CORES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reqValid,
  output logic                        reqReady,
  input  logic [PRIO_W-1:0]           reqPrio,
  input  logic [NUM_CORES-1:0]        reqPool,
  input  logic [NUM_CORES-1:0]        coreReady,
  input  logic [NUM_CORES*PRIO_W-1:0] corePrio,
  output logic                        pickValid,
  output logic [IDX_W-1:0]            pickCore,
  output logic                        missPulse
);

  selStrobe_t strobe;
  logic       anyHit;

  pool_sel_ctrl #(
    .FIFO_DEPTH(FIFO_DEPTH),
    .RETRY_GAP (RETRY_GAP)
  ) i_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .reqValid(reqValid),
    .anyHit  (anyHit),
    .reqReady(reqReady),
    .strobe  (strobe)
  );

  pool_sel_dp #(
    .NUM_CORES (NUM_CORES),
    .PRIO_W    (PRIO_W),
    .FIFO_DEPTH(FIFO_DEPTH)
  ) i_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .reqPrio  (reqPrio),
    .reqPool  (reqPool),
    .coreReady(coreReady),
    .corePrio (corePrio),
    .anyHit   (anyHit),
    .pickValid(pickValid),
    .pickCore (pickCore),
    .missPulse(missPulse)
  );

endmodule

// File: tb/test_core_pool_selector.sv
module test_core_pool_selector;
  localparam int NC   = 8;
  localparam int PW   = 6;
  localparam int DEP  = 4;
  localparam int GAP  = 3;
  localparam int IW   = $clog2(NC);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic [PW-1:0] reqPrio = '0;
  logic [NC-1:0] reqPool = '0;
  logic [NC-1:0] coreReady = '0;
  logic [NC*PW-1:0] corePrio = '0;
  logic          pickValid;
  logic [IW-1:0] pickCore;
  logic          missPulse;

  logic [PW-1:0] cp [NC];
  int vectors = 0;
  int fails = 0;

  always #10 clk = ~clk;  // 50 MHz

  core_pool_selector #(.NUM_CORES(NC), .PRIO_W(PW), .FIFO_DEPTH(DEP), .RETRY_GAP(GAP))
  i_core_pool_selector (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady),
    .reqPrio(reqPrio), .reqPool(reqPool), .coreReady(coreReady),
    .corePrio(corePrio), .pickValid(pickValid), .pickCore(pickCore),
    .missPulse(missPulse)
  );

  task automatic chk(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic packCores();
    for (int i = 0; i < NC; i++) corePrio[i*PW +: PW] = cp[i];
  endtask

  // Reference: -1 if no eligible core, else chosen index.
  function automatic int model(logic [PW-1:0] ip, logic [NC-1:0] pool);
    int best = -1;
    for (int i = 0; i < NC; i++)
      if (pool[i] && coreReady[i] && cp[i] < ip)
        if (best < 0 || cp[i] < cp[best]) best = i;
    return best;
  endfunction

  function automatic int lowestBit(logic [NC-1:0] v);
    for (int i = 0; i < NC; i++) if (v[i]) return i;
    return -1;
  endfunction

  // Called at a negedge; returns at the negedge where the result is visible.
  task automatic sendOne(logic [PW-1:0] ip, logic [NC-1:0] pool, string req, output int exp);
    reqPrio = ip; reqPool = pool; reqValid = 1'b1;
    chk(req, "reqReady before send", int'(reqReady), 1);
    exp = model(ip, pool);
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    if (exp < 0) begin
      chk(req, "missPulse on no eligible core", int'(missPulse), 1);
      chk(req, "pickValid on miss", int'(pickValid), 0);
    end else begin
      chk(req, "pickValid", int'(pickValid), 1);
      chk(req, "pickCore", int'(pickCore), exp);
      chk(req, "missPulse on hit", int'(missPulse), 0);
    end
  endtask

  // Make all cores free and wait for the parked interrupt to land.
  task automatic drain(logic [NC-1:0] pool);
    int got = -1;
    coreReady = '1;
    for (int i = 0; i < NC; i++) cp[i] = '0;
    packCores();
    for (int k = 0; k < GAP + 4; k++) begin
      @(negedge clk);
      if (pickValid && got < 0) got = int'(pickCore);
    end
    chk("R6", "retry uses stored mask", got, lowestBit(pool));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R4 watchdog expired: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int exp;
    int picks [6];
    int nPicks;
    int missAt [4];
    int nMiss;
    logic sent;

    for (int i = 0; i < NC; i++) cp[i] = '0;
    packCores();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8", "pickValid in reset", int'(pickValid), 0);
    chk("R8", "missPulse in reset", int'(missPulse), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8", "reqReady after reset", int'(reqReady), 1);
    chk("R8", "pickValid after reset", int'(pickValid), 0);

    // R3 tie: all at 5, mask 1011_0100, interrupt 9 -> core 2.
    coreReady = '1;
    for (int i = 0; i < NC; i++) cp[i] = 6'd5;
    packCores();
    sendOne(6'd9, 8'b1011_0100, "R3", exp);
    chk("R3", "tie goes to lowest index", exp, 2);

    // R2 minimum with a tie at the minimum: cores 3 and 6 at 2.
    cp[0] = 10; cp[1] = 4; cp[2] = 7; cp[3] = 2; cp[4] = 9; cp[5] = 3; cp[6] = 2; cp[7] = 1;
    packCores();
    sendOne(6'd12, 8'b0111_1110, "R2", exp);
    chk("R2", "min priority core", exp, 3);

    // R1 boundary: running priority equal to interrupt is not eligible.
    for (int i = 0; i < NC; i++) cp[i] = 6'd7;
    packCores();
    sendOne(6'd7, 8'hFF, "R1", exp);
    chk("R5", "equal priority misses", exp, -1);
    drain(8'hFF);

    // Sweep against the model.
    for (int n = 0; n < 1500; n++) begin
      logic [PW-1:0] ip;
      logic [NC-1:0] pool;
      for (int i = 0; i < NC; i++) cp[i] = PW'($urandom % 64);
      packCores();
      coreReady = NC'($urandom) | NC'($urandom);
      pool = NC'($urandom);
      if (pool == '0) pool = 8'h01;
      ip = PW'(1 + ($urandom % 63));
      sendOne(ip, pool, "R1", exp);
      if (exp < 0) drain(pool);
    end

    // R7: fill the queue back to back, then drain oldest first.
    coreReady = '0;
    for (int k = 0; k < DEP; k++) sendOne(6'd20, NC'(1 << k), "R5", exp);
    chk("R7", "reqReady low when full", int'(reqReady), 0);
    coreReady = '1;
    for (int i = 0; i < NC; i++) cp[i] = '0;
    packCores();
    reqPrio = 6'd20; reqPool = 8'h80; reqValid = 1'b1;
    nPicks = 0; sent = 1'b0;
    for (int k = 0; k < 20; k++) begin
      if (sent) reqValid = 1'b0;
      if (reqValid && reqReady) sent = 1'b1;
      else if (reqValid && nPicks < DEP)
        chk("R6", "new request blocked while queue drains", int'(reqReady), 0);
      @(negedge clk);
      if (pickValid && nPicks < 6) begin picks[nPicks] = int'(pickCore); nPicks++; end
    end
    reqValid = 1'b0;
    chk("R7", "picks during drain", nPicks, DEP + 1);
    for (int k = 0; k < DEP; k++) chk("R7", "oldest first", picks[k], k);
    chk("R6", "new request after queue", picks[DEP], 7);

    // R9: one parked interrupt keeps missing every GAP+1 cycles.
    coreReady = '0;
    sendOne(6'd30, 8'h40, "R9", exp);
    nMiss = 0;
    for (int k = 1; k <= 3 * (GAP + 1); k++) begin
      @(negedge clk);
      if (missPulse) begin
        if (nMiss < 4) missAt[nMiss] = k;
        nMiss++;
      end
      chk("R9", "no pick while busy", int'(pickValid), 0);
    end
    chk("R9", "re-miss count", nMiss, 3);
    chk("R9", "first re-miss offset", missAt[0], GAP + 1);
    chk("R9", "re-miss period", missAt[1] - missAt[0], GAP + 1);
    // Stored priority 30: core 5 at 31 must be skipped, core 6 at 29 wins.
    coreReady = 8'h60;
    cp[5] = 6'd31; cp[6] = 6'd29;
    packCores();
    exp = -1;
    for (int k = 0; k < GAP + 3; k++) begin
      @(negedge clk);
      if (pickValid) exp = int'(pickCore);
    end
    chk("R6", "retry uses stored priority", exp, 6);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule